// File: doc/BRIEF.md
# Key Matrix Scanner with Serial Readout

This block scans a key matrix of 12 columns by 4 return rows. It uses the idle key slot that the display scanner leaves in each frame. It drives one column at a time onto the shared segment lines, samples the four return inputs and builds a 48-bit picture of the matrix in a shadow buffer. A complete pass takes two display frames. Columns 1 to 6 are scanned in the slot of the first frame and columns 7 to 12 in the slot of the second. When the pass finishes, the whole shadow buffer is copied in one cycle into the readable key RAM. A reader therefore sees either the old scan or the new one, never a mix of the two.

The key RAM is read one bit per request, starting at bit 0, and the read position wraps around. A 4-bit switch port is captured when a read sequence is restarted and is read in the same way, as one byte.

Scanning is off after reset. The start command turns it on. It keeps running until a halt, which stops it at once and releases the columns.

The sequencer states are: IDLE (stopped), WAIT_A (waiting for the first frame), ARM_A (waiting for that frame's key slot), SCAN_A (columns 1 to 6), WAIT_B, ARM_B and SCAN_B (the same for the second frame, columns 7 to 12), and COMMIT (a one-cycle copy of the shadow buffer into the RAM). The transitions are:
- IDLE goes to WAIT_A on start.
- WAIT_A goes to ARM_A, and WAIT_B goes to ARM_B, on a frame-start pulse.
- ARM_x goes to SCAN_x when the slot becomes active.
- SCAN_A goes to WAIT_B after column 6, or when the slot ends early.
- SCAN_B goes to COMMIT after column 12. If the slot ends early it goes back to WAIT_A and the partial pass is dropped.
- COMMIT goes to WAIT_A.
- A halt takes any state to IDLE.

Top module: `kscan_top`

## Requirements
- R1: After reset no column is driven, all 48 key RAM bits read as 0 and scanning is stopped.
- R2: While stopped, frame and slot activity drive no column. Scanning begins only after a start pulse, with the next frame-start pulse.
- R3: At most one column is driven at a time, and only while the slot is active. The first frame's slot drives columns 1 to 6 in ascending order and the second frame's slot drives columns 7 to 12 in ascending order. Each column is driven for SHARE_CYC (4) consecutive cycles.
- R4: The return rows are sampled in the last cycle of each column's share. Row r (0 to 3) of column c (0 to 11) is stored at bit index 4c+r. Byte i therefore holds column 2i+1 in bits 0 to 3 and column 2i+2 in bits 4 to 7.
- R5: The key RAM changes only in the single cycle after the second frame's scan completes. Reads in between return the previous pass.
- R6: A key read (rd_req with rd_sel=0) returns the RAM bit at the read position in rd_bit the next cycle, then advances the position. After bit 47 it continues at bit 0.
- R7: A switch read (rd_sel=1) returns a byte with the switches captured at the last rd_rst in bits 0 to 3 and zeros in bits 4 to 7, LSB first. It wraps every 8 bits. Switch changes after the capture do not appear.
- R8: A halt stops scanning in the next cycle and releases all columns, and the key RAM keeps its contents. A start pulse while scanning is already running has no effect on the pass in progress.
- R9: rd_rst sets both read positions back to bit 0.
- R10: Scanning repeats pass after pass without a new start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scan_start | input | 1 | Pulse: enable scanning |
| scan_halt | input | 1 | Pulse: stop scanning |
| frm_start | input | 1 | Pulse: a display frame begins |
| slot_act | input | 1 | High during the frame's key slot |
| col_drv | output | 12 | One-hot column drive |
| key_in | input | 4 | Key return rows |
| sw_in | input | 4 | Switch inputs |
| rd_req | input | 1 | Request one read bit |
| rd_sel | input | 1 | 0 = key RAM, 1 = switch byte |
| rd_rst | input | 1 | Restart read positions and capture switches |
| rd_bit | output | 1 | Read data, valid the cycle after rd_req |

## Verification
The bench goes after the swap from the first half to the second half of the matrix. A design that sampled the wrong column range in a frame would put keys at the wrong bit positions. It also checks that the RAM does not change between the two frames: a design that wrote straight into the readable RAM would return a half-new pattern there. The wrap after bit 47 is read across, where a design with an off-by-one pointer would repeat or skip a bit. Halting mid-slot must leave the RAM intact, and a repeated start during a pass must not restart the pass. A design that restarted it would treat the second frame as a first one and never commit.

// File: rtl/kscan_pkg.sv
package kscan_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_A,
        ST_ARM_A,
        ST_SCAN_A,
        ST_WAIT_B,
        ST_ARM_B,
        ST_SCAN_B,
        ST_COMMIT
    } kscan_state_e;
endpackage

// File: rtl/kscan_seq.sv
module kscan_seq
    import kscan_pkg::*;
#(
    parameter int N_COL     = 12,
    parameter int SHARE_CYC = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       scan_start,
    input  logic                       scan_halt,
    input  logic                       frm_start,
    input  logic                       slot_act,
    output logic [N_COL-1:0]           col_drv,
    output logic                       sample,
    output logic                       commit,
    output logic [$clog2(N_COL)-1:0]   col_idx,
    output kscan_state_e               state
);
    localparam int HALF = N_COL / 2;
    localparam int CW   = $clog2(N_COL);
    localparam int TW   = $clog2(SHARE_CYC + 1);

    kscan_state_e       nxt;
    logic [CW-1:0]      col_q;
    logic [TW-1:0]      tick_q;
    logic               last_tick;
    logic               scanning;

    assign last_tick = (tick_q == TW'(SHARE_CYC - 1));
    assign scanning  = (state == ST_SCAN_A) || (state == ST_SCAN_B);

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (scan_start) nxt = ST_WAIT_A;
            ST_WAIT_A: if (frm_start)  nxt = ST_ARM_A;
            ST_ARM_A:  if (slot_act)   nxt = ST_SCAN_A;
            ST_SCAN_A: if (!slot_act || (last_tick && col_q == CW'(HALF - 1)))
                           nxt = ST_WAIT_B;
            ST_WAIT_B: if (frm_start)  nxt = ST_ARM_B;
            ST_ARM_B:  if (slot_act)   nxt = ST_SCAN_B;
            ST_SCAN_B: begin
                if (!slot_act)
                    nxt = ST_WAIT_A;
                else if (last_tick && col_q == CW'(N_COL - 1))
                    nxt = ST_COMMIT;
            end
            ST_COMMIT: nxt = ST_WAIT_A;
            default:   nxt = ST_IDLE;
        endcase
        if (scan_halt) nxt = ST_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            col_q  <= '0;
            tick_q <= '0;
        end else begin
            state <= nxt;
            if (state == ST_ARM_A) begin
                col_q  <= '0;
                tick_q <= '0;
            end else if (state == ST_ARM_B) begin
                col_q  <= CW'(HALF);
                tick_q <= '0;
            end else if (scanning) begin
                if (last_tick) begin
                    tick_q <= '0;
                    col_q  <= col_q + 1'b1;
                end else begin
                    tick_q <= tick_q + 1'b1;
                end
            end
        end
    end

    always_comb begin
        col_drv = '0;
        if (scanning && slot_act)
            col_drv[col_q] = 1'b1;
        sample  = scanning && slot_act && last_tick;
        commit  = (state == ST_COMMIT);
        col_idx = col_q;
    end
endmodule

// File: rtl/kscan_store.sv
module kscan_store #(
    parameter int N_COL = 12,
    parameter int N_ROW = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       sample,
    input  logic                       commit,
    input  logic [$clog2(N_COL)-1:0]   col_idx,
    input  logic [N_ROW-1:0]           key_in,
    output logic [N_COL*N_ROW-1:0]     key_ram
);
    localparam int KB = N_COL * N_ROW;
    localparam int CW = $clog2(N_COL);

    logic [KB-1:0] shadow;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shadow  <= '0;
            key_ram <= '0;
        end else begin
            for (int c = 0; c < N_COL; c++) begin
                if (sample && col_idx == CW'(c))
                    shadow[c*N_ROW +: N_ROW] <= key_in;
            end
            if (commit)
                key_ram <= shadow;
        end
    end
endmodule

// File: rtl/kscan_rdout.sv
module kscan_rdout #(
    parameter int KB   = 48,
    parameter int N_SW = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [KB-1:0]             key_ram,
    input  logic [N_SW-1:0]           sw_in,
    input  logic                      rd_req,
    input  logic                      rd_sel,
    input  logic                      rd_rst,
    output logic                      rd_bit,
    output logic [$clog2(KB)-1:0]     kptr
);
    localparam int KPW = $clog2(KB);

    logic [N_SW-1:0] sw_lat;
    logic [2:0]      sptr;
    logic [7:0]      sw_byte;

    assign sw_byte = {{(8-N_SW){1'b0}}, sw_lat};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kptr   <= '0;
            sptr   <= '0;
            sw_lat <= '0;
            rd_bit <= 1'b0;
        end else if (rd_rst) begin
            kptr   <= '0;
            sptr   <= '0;
            sw_lat <= sw_in;
        end else if (rd_req) begin
            if (rd_sel) begin
                rd_bit <= sw_byte[sptr];
                sptr   <= sptr + 1'b1;
            end else begin
                rd_bit <= key_ram[kptr];
                kptr   <= (kptr == KPW'(KB - 1)) ? '0 : kptr + 1'b1;
            end
        end
    end
endmodule

// File: rtl/kscan_top.sv
module kscan_top
    import kscan_pkg::*;
#(
    parameter int N_COL     = 12,
    parameter int N_ROW     = 4,
    parameter int N_SW      = 4,
    parameter int SHARE_CYC = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scan_start,
    input  logic             scan_halt,
    input  logic             frm_start,
    input  logic             slot_act,
    output logic [N_COL-1:0] col_drv,
    input  logic [N_ROW-1:0] key_in,
    input  logic [N_SW-1:0]  sw_in,
    input  logic             rd_req,
    input  logic             rd_sel,
    input  logic             rd_rst,
    output logic             rd_bit
);
    localparam int KB = N_COL * N_ROW;

    logic                      sample;
    logic                      commit;
    logic [$clog2(N_COL)-1:0]  col_idx;
    kscan_state_e              state;
    logic [KB-1:0]             key_ram;
    logic [$clog2(KB)-1:0]     kptr;

    kscan_seq #(.N_COL(N_COL), .SHARE_CYC(SHARE_CYC)) u_seq (
        .clk(clk), .rst_n(rst_n), .scan_start(scan_start), .scan_halt(scan_halt),
        .frm_start(frm_start), .slot_act(slot_act), .col_drv(col_drv),
        .sample(sample), .commit(commit), .col_idx(col_idx), .state(state)
    );

    kscan_store #(.N_COL(N_COL), .N_ROW(N_ROW)) u_store (
        .clk(clk), .rst_n(rst_n), .sample(sample), .commit(commit),
        .col_idx(col_idx), .key_in(key_in), .key_ram(key_ram)
    );

    kscan_rdout #(.KB(KB), .N_SW(N_SW)) u_rd (
        .clk(clk), .rst_n(rst_n), .key_ram(key_ram), .sw_in(sw_in),
        .rd_req(rd_req), .rd_sel(rd_sel), .rd_rst(rd_rst),
        .rd_bit(rd_bit), .kptr(kptr)
    );
endmodule

// File: rtl/kscan_chk.sv
module kscan_chk
    import kscan_pkg::*;
#(
    parameter int N_COL = 12,
    parameter int KB    = 48
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   scan_halt,
    input  logic [N_COL-1:0]       col_drv,
    input  logic                   commit,
    input  logic [KB-1:0]          key_ram,
    input  kscan_state_e           state,
    input  logic                   rd_req,
    input  logic                   rd_sel,
    input  logic                   rd_rst,
    input  logic [$clog2(KB)-1:0]  kptr
);
    localparam int HALF = N_COL / 2;

    p_onehot_col_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(col_drv));

    p_first_half_r3: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_SCAN_A |-> col_drv[N_COL-1:HALF] == '0);

    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_IDLE |-> col_drv == '0);

    p_halt_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        scan_halt |=> (state == ST_IDLE && col_drv == '0));

    p_ram_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(key_ram));

    p_key_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_sel && !rd_rst && kptr == $bits(kptr)'(KB - 1)) |=> kptr == '0);

    p_ptr_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_rst |=> kptr == '0);
endmodule

bind kscan_top kscan_chk #(.N_COL(N_COL), .KB(KB)) u_chk (
    .clk(clk), .rst_n(rst_n), .scan_halt(scan_halt), .col_drv(col_drv),
    .commit(commit), .key_ram(key_ram), .state(state), .rd_req(rd_req),
    .rd_sel(rd_sel), .rd_rst(rd_rst), .kptr(kptr)
);

// File: tb/kscan_top_tb_top.sv
`timescale 1ns/1ps
module kscan_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scan_start = 0, scan_halt = 0, frm_start = 0, slot_act = 0;
    logic [11:0] col_drv;
    logic [3:0]  key_in;
    logic [3:0]  sw_in = 4'h0;
    logic        rd_req = 0, rd_sel = 0, rd_rst = 0;
    logic        rd_bit;
    logic [47:0] pressed = '0;

    int checks = 0, fails = 0;
    int col_hits [12];
    int order_bad = 0, half_bad = 0, slot_bad = 0, any_drive = 0;
    int last_col = -1;
    int cur_half = 0;

    localparam logic [47:0] PATS [6] = '{
        48'h0000_0000_0000, 48'hFFFF_FFFF_FFFF, 48'h0000_0000_0001,
        48'h8000_0000_0000, 48'hA5A5_5A5A_A5A5, 48'h1234_5678_9ABC
    };

    always #2.5 clk = ~clk;

    kscan_top dut_i (
        .clk(clk), .rst_n(rst_n), .scan_start(scan_start), .scan_halt(scan_halt),
        .frm_start(frm_start), .slot_act(slot_act), .col_drv(col_drv),
        .key_in(key_in), .sw_in(sw_in), .rd_req(rd_req), .rd_sel(rd_sel),
        .rd_rst(rd_rst), .rd_bit(rd_bit)
    );

    always_comb begin
        key_in = '0;
        for (int c = 0; c < 12; c++)
            if (col_drv[c]) key_in = key_in | pressed[c*4 +: 4];
    end

    always @(negedge clk) begin
        if (rst_n && col_drv != '0) begin
            any_drive++;
            if (!slot_act || !$onehot(col_drv)) slot_bad++;
            for (int c = 0; c < 12; c++) begin
                if (col_drv[c]) begin
                    col_hits[c]++;
                    if (c != last_col && c != last_col + 1 && c != 0 && c != 6) order_bad++;
                    if ((cur_half == 0 && c >= 6) || (cur_half == 1 && c < 6)) half_bad++;
                    last_col = c;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_frame(input int half, input int slot_len);
        cur_half = half;
        frm_start = 1; tick(1); frm_start = 0;
        tick(3);
        slot_act = 1; tick(slot_len); slot_act = 0;
        tick(2);
    endtask

    task automatic pulse_start(); scan_start = 1; tick(1); scan_start = 0; endtask
    task automatic pulse_rrst();  rd_rst = 1; tick(1); rd_rst = 0; endtask

    task automatic read_bits(input bit sel, input int n, output logic [63:0] v);
        v = '0;
        for (int i = 0; i < n; i++) begin
            rd_req = 1; rd_sel = sel; tick(1);
            rd_req = 0;
            v[i] = rd_bit;
        end
    endtask

    task automatic clear_mon();
        for (int c = 0; c < 12; c++) col_hits[c] = 0;
        order_bad = 0; half_bad = 0; slot_bad = 0; any_drive = 0; last_col = -1;
    endtask

    initial begin
        #1_000_000;
        fails++; checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_up();
    end

    initial begin
        logic [63:0] v;
        clear_mon();
        tick(3);
        rst_n = 1;
        tick(1);
        // R1: reset state
        chk(col_drv == '0, "R1 col_drv after reset", 64'(col_drv), 0);
        pulse_rrst();
        read_bits(0, 48, v);
        chk(v[47:0] == '0, "R1 key RAM after reset", v, 0);

        // R2: no scanning before start
        pressed = 48'hFFFF_FFFF_FFFF;
        do_frame(0, 26); do_frame(1, 26);
        chk(any_drive == 0, "R2 columns idle while stopped", 64'(any_drive), 0);

        // R3/R4/R10: table of patterns, one pass each
        pulse_start();
        foreach (PATS[p]) begin
            pressed = PATS[p];
            clear_mon();
            do_frame(0, 26);
            do_frame(1, 26);
            pulse_rrst();
            read_bits(0, 48, v);
            chk(v[47:0] == PATS[p], "R4 R10 key stream for pattern", v, 64'(PATS[p]));
            for (int c = 0; c < 12; c++)
                chk(col_hits[c] == 4, "R3 column share length", 64'(col_hits[c]), 4);
            chk(order_bad == 0 && half_bad == 0 && slot_bad == 0,
                "R3 column order/half/slot", 64'(order_bad + half_bad + slot_bad), 0);
        end

        // R5: RAM unchanged between the two frames
        pressed = 48'h0F0F_0F0F_0F0F;
        do_frame(0, 26);
        pulse_rrst();
        read_bits(0, 48, v);
        chk(v[47:0] == PATS[5], "R5 old data after first frame", v, 64'(PATS[5]));
        do_frame(1, 26);
        pulse_rrst();
        read_bits(0, 48, v);
        chk(v[47:0] == 48'h0F0F_0F0F_0F0F, "R5 new data after second frame", v, 64'h0F0F0F0F0F0F);

        // R6: wrap after bit 47
        pulse_rrst();
        read_bits(0, 48, v);
        read_bits(0, 2, v);
        chk(v[1:0] == 2'b11, "R6 wrap to bit 0", 64'(v[1:0]), 3);

        // R9: restart pointer mid-stream
        pulse_rrst();
        read_bits(0, 5, v);
        pulse_rrst();
        read_bits(0, 1, v);
        chk(v[0] == 1'b1, "R9 restart reads bit 0", 64'(v[0]), 1);

        // R8: start during a pass does not restart it
        pressed = 48'hC000_0000_0003;
        do_frame(0, 26);
        pulse_start();
        do_frame(1, 26);
        pulse_rrst();
        read_bits(0, 48, v);
        chk(v[47:0] == 48'hC000_0000_0003, "R8 start while running ignored", v, 64'hC00000000003);

        // R8: halt mid-slot
        pressed = 48'hFFFF_FFFF_FFFF;
        cur_half = 0;
        frm_start = 1; tick(1); frm_start = 0; tick(3);
        slot_act = 1; tick(6);
        scan_halt = 1; tick(1); scan_halt = 0;
        chk(col_drv == '0, "R8 columns released after halt", 64'(col_drv), 0);
        tick(10); slot_act = 0; tick(2);
        clear_mon();
        do_frame(0, 26); do_frame(1, 26);
        chk(any_drive == 0, "R8 no drive after halt", 64'(any_drive), 0);
        pulse_rrst();
        read_bits(0, 48, v);
        chk(v[47:0] == 48'hC000_0000_0003, "R8 RAM kept after halt", v, 64'hC00000000003);

        // R7: switch byte, capture and wrap
        sw_in = 4'b1010;
        pulse_rrst();
        sw_in = 4'b0101;
        read_bits(1, 16, v);
        chk(v[15:0] == 16'h0A0A, "R7 switch byte with wrap and capture", 64'(v[15:0]), 64'h0A0A);
        pulse_rrst();
        read_bits(1, 8, v);
        chk(v[7:0] == 8'h05, "R7 switch recapture", 64'(v[7:0]), 5);

        finish_up();
    end
endmodule